// File: doc/BRIEF.md
# Serial SAR ADC output emulator

This block is a synthesizable device-side model of a three-wire, 12-bit successive-approximation converter. A serial master controls it with an active-low select and a serial clock. The block takes the value to convert on a parallel input and answers on a single data line. A separate enable output stands in for the high-impedance state of a real pin. Test benches can use it as a converter stand-in, and it can also serve as a loopback target for a serial master under test.

A frame starts when select goes low. The first falling serial-clock edge is the sampling interval, during which the line is still released. The second falling edge drives a low null bit and captures the input value. The next twelve falling edges send the captured word most significant bit first. When the repeat option is on, the word is then sent again least significant bit first, with the final bit of the first word shared between the two. After that the line carries zeros for as long as the master keeps clocking. Raising select ends the frame at any point and puts the model into shutdown.

Top module: `sar_adc_emu`

## Requirements
- R1: While `cs_n` is high, `sdo_oe` is 0, `sdo` is 0 and `shutdown` is 1, and falling `sclk` edges have no effect.
- R2: After `cs_n` falls, `sdo_oe` stays 0 through the first SAMPLE_FALLS falling `sclk` edges (default 1).
- R3: On falling edge SAMPLE_FALLS+1 (default edge 2), `sdo_oe` becomes 1 and `sdo` is 0. This is the null bit.
- R4: On falling edges 3 to 14 (defaults), `sdo` carries the captured value from bit 11 down to bit 0, one bit per edge.
- R5: With LSB_REPEAT=1, falling edges 15 to 25 carry bit 1 up to bit 11 in ascending order. Bit 0, sent on edge 14, opens this reversed sequence.
- R6: After the last data bit, each further falling edge with `cs_n` low keeps `sdo_oe` at 1 and `sdo` at 0, without limit.
- R7: Outputs change only in the `clk` cycle after a high-to-low `sclk` transition is seen, or after `cs_n` changes. A rising `sclk` edge changes nothing.
- R8: `sample_i` is captured on the null-bit edge. Later changes to it within the frame do not affect the bits sent.
- R9: A rising `cs_n` aborts the frame: `sdo_oe` is 0 one `clk` cycle later. The next frame starts again from the sampling interval.
- R10: With LSB_REPEAT=0, every edge after bit 0 drives 0.
- R11: After reset, `sdo_oe` is 0, `sdo` is 0 and `shutdown` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples the serial inputs |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Active-low select; high means shutdown |
| sclk | input | 1 | Serial clock from the master, synchronous to `clk` |
| sample_i | input | DATA_W | Value to convert |
| sdo | output | 1 | Serial data |
| sdo_oe | output | 1 | 1 when `sdo` is driven, 0 for high impedance |
| shutdown | output | 1 | 1 while deselected |

## Verification
The assertions check several rules on every cycle. Deselect must release the line and raise shutdown. The first driven bit must be low. Outputs may move only after a falling serial edge or a select change. A fresh frame must start released. The captured word must not move once the frame is past sampling. Only the bench scenarios can show the actual bit order: the descending word, the shared-bit reverse sequence, the zero tail, the effect of the repeat option, and the fact that a frame restarted after an abort carries the new value.

// File: rtl/sar_emu_pkg.sv
// Shared types for the serial SAR ADC emulator.
// Assumes nothing beyond IEEE 1800-2017.
package sar_emu_pkg;
    // Position of the current frame as seen on the data line.
    typedef enum logic [2:0] {
        PH_SAMPLE,  // line released, input being sampled
        PH_NULL,    // low null bit
        PH_MSB,     // word, descending bit order
        PH_LSB,     // word, ascending bit order
        PH_ZERO     // trailing zeros
    } phase_t;
endpackage

// File: rtl/sar_emu_edge.sv
// Detects falling edges of the master serial clock while selected, and
// registers the select line. Assumes sclk and cs_n are already
// synchronous to clk and that each sclk level lasts at least one clk cycle.
module sar_emu_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic sclk,
    output logic sclk_fall,
    output logic cs_q
);
    logic sclk_q;

    // Keep last sclk level and registered select.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_q <= 1'b0;
            cs_q   <= 1'b1;
        end else begin
            sclk_q <= sclk;
            cs_q   <= cs_n;
        end
    end

    // A high-to-low transition counts only while selected.
    assign sclk_fall = sclk_q & ~sclk & ~cs_n;
endmodule

// File: rtl/sar_emu_frame_ctr.sv
// Counts falling serial edges within a frame and decodes the frame phase
// and the bit index to send. The count saturates after the last data bit,
// so the zero tail lasts indefinitely. Assumes sclk_fall is gated by select.
module sar_emu_frame_ctr
    import sar_emu_pkg::*;
#(
    parameter int DATA_W       = 12,
    parameter int SAMPLE_FALLS = 1,
    parameter bit LSB_REPEAT   = 1'b1,
    localparam int IW          = $clog2(DATA_W)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs_n,
    input  logic          sclk_fall,
    output phase_t        phase,
    output logic [IW-1:0] bit_sel,
    output logic          latch_en
);
    localparam int NULL_IDX = SAMPLE_FALLS + 1;
    localparam int MSB_LAST = NULL_IDX + DATA_W;
    localparam int LSB_LAST = NULL_IDX + 2 * DATA_W - 1;
    localparam int CNT_MAX  = LSB_LAST + 1;
    localparam int CW       = $clog2(CNT_MAX + 1);
    localparam logic [CW-1:0] NULL_C = CW'(NULL_IDX);
    localparam logic [CW-1:0] MSB_C  = CW'(MSB_LAST);
    localparam logic [CW-1:0] LSB_C  = CW'(LSB_LAST);
    localparam logic [CW-1:0] MAX_C  = CW'(CNT_MAX);

    logic [CW-1:0] cnt;
    logic [CW-1:0] cnt_next;
    logic          lsb_win;

    // Saturating successor of the edge count.
    assign cnt_next = (cnt == MAX_C) ? cnt : cnt + 1'b1;

    // Edge counter: cleared while deselected, advanced on each falling edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (cs_n) begin
            cnt <= '0;
        end else if (sclk_fall) begin
            cnt <= cnt_next;
        end
    end

    // Capture strobe on the edge that enters the null bit.
    assign latch_en = sclk_fall && (cnt_next == NULL_C);

    // Reversed-word window exists only when the repeat option is on.
    generate
        if (LSB_REPEAT) begin : g_rep
            assign lsb_win = (cnt > MSB_C) && (cnt <= LSB_C);
        end else begin : g_norep
            assign lsb_win = 1'b0;
        end
    endgenerate

    // Phase decode from the edge count.
    always_comb begin
        if (cnt < NULL_C)       phase = PH_SAMPLE;
        else if (cnt == NULL_C) phase = PH_NULL;
        else if (cnt <= MSB_C)  phase = PH_MSB;
        else if (lsb_win)       phase = PH_LSB;
        else                    phase = PH_ZERO;
    end

    // Bit index: descending in the first word, ascending in the repeat.
    always_comb begin
        if (phase == PH_LSB) bit_sel = IW'(int'(cnt) - MSB_LAST);
        else if (phase == PH_MSB) bit_sel = IW'(MSB_LAST - int'(cnt));
        else bit_sel = '0;
    end
endmodule

// File: rtl/sar_emu_out.sv
// Holds the captured sample and drives the data line and its enable from
// the frame phase. Assumes latch_en pulses once per frame, at null-bit entry.
module sar_emu_out
    import sar_emu_pkg::*;
#(
    parameter int DATA_W = 12,
    localparam int IW    = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] sample_i,
    input  logic              latch_en,
    input  phase_t            phase,
    input  logic [IW-1:0]     bit_sel,
    output logic              sdo,
    output logic              sdo_oe
);
    logic [DATA_W-1:0] sample_q;

    // Capture the conversion value at the end of sampling.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sample_q <= '0;
        end else if (latch_en) begin
            sample_q <= sample_i;
        end
    end

    // Data line: word bits in both word phases, low otherwise.
    always_comb begin
        if (phase == PH_MSB || phase == PH_LSB) sdo = sample_q[bit_sel];
        else                                    sdo = 1'b0;
    end

    // Line is driven from the null bit onward.
    assign sdo_oe = (phase != PH_SAMPLE);

    // R8: the captured word does not move once the frame is past sampling.
    assert_word_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (phase != PH_SAMPLE && $past(phase) != PH_SAMPLE) |-> $stable(sample_q));
endmodule

// File: rtl/sar_adc_emu.sv
// Device-side model of a three-wire 12-bit serial SAR converter: sampling
// interval, null bit, descending word, optional ascending repeat, zero tail
// and shutdown while deselected. Assumes sclk and cs_n synchronous to clk.
module sar_adc_emu
    import sar_emu_pkg::*;
#(
    parameter int DATA_W       = 12,
    parameter int SAMPLE_FALLS = 1,
    parameter bit LSB_REPEAT   = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              sclk,
    input  logic [DATA_W-1:0] sample_i,
    output logic              sdo,
    output logic              sdo_oe,
    output logic              shutdown
);
    localparam int IW = $clog2(DATA_W);

    logic          sclk_fall;
    logic          cs_q;
    logic          latch_en;
    phase_t        phase;
    logic [IW-1:0] bit_sel;

    sar_emu_edge u_edge (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_n      (cs_n),
        .sclk      (sclk),
        .sclk_fall (sclk_fall),
        .cs_q      (cs_q)
    );

    sar_emu_frame_ctr #(
        .DATA_W       (DATA_W),
        .SAMPLE_FALLS (SAMPLE_FALLS),
        .LSB_REPEAT   (LSB_REPEAT)
    ) u_ctr (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_n      (cs_n),
        .sclk_fall (sclk_fall),
        .phase     (phase),
        .bit_sel   (bit_sel),
        .latch_en  (latch_en)
    );

    sar_emu_out #(
        .DATA_W (DATA_W)
    ) u_out (
        .clk      (clk),
        .rst_n    (rst_n),
        .sample_i (sample_i),
        .latch_en (latch_en),
        .phase    (phase),
        .bit_sel  (bit_sel),
        .sdo      (sdo),
        .sdo_oe   (sdo_oe)
    );

    // Shutdown follows the registered select.
    assign shutdown = cs_q;

    // R1: deselect releases the line and enters shutdown.
    assert_deselect_hiz_R1: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> (shutdown && !sdo_oe && !sdo));

    // R3: the first driven bit of a frame is low.
    assert_null_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sdo_oe) |-> !sdo);

    // R7: outputs move only after a falling serial edge or a select change.
    assert_launch_fall_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(sdo) || !$stable(sdo_oe)) |-> ($past(sclk_fall) || $past(cs_n)));

    // R9: a new frame starts with the line released.
    assert_restart_hiz_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cs_n) |=> !sdo_oe);
endmodule

// File: tb/sar_adc_emu_tb.sv
// Scoreboard bench: the driver queues expected line states per falling
// edge, and the monitor pops and compares them once the edge takes effect.
module sar_adc_emu_tb;
    localparam int DW = 12;

    typedef struct {
        logic  oe;
        logic  sdo;
        logic  sdo2;
        logic  sd;
        string tag;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          cs_n;
    logic          sclk;
    logic [DW-1:0] sample;
    logic          sdo, oe, sd, sdo2, oe2, sd2;

    exp_t sbq[$];
    exp_t last_e;
    event ev_obs;
    int   checks = 0;
    int   errors = 0;
    bit   done   = 1'b0;

    always #2 clk = ~clk;

    sar_adc_emu #(.DATA_W(DW), .SAMPLE_FALLS(1), .LSB_REPEAT(1'b1)) u_dut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk),
        .sample_i(sample), .sdo(sdo), .sdo_oe(oe), .shutdown(sd));

    sar_adc_emu #(.DATA_W(DW), .SAMPLE_FALLS(1), .LSB_REPEAT(1'b0)) u_dut_norep (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk),
        .sample_i(sample), .sdo(sdo2), .sdo_oe(oe2), .shutdown(sd2));

    task automatic check1(string tag, string what, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0b expected=%0b at %0t", tag, what, act, exp, $time);
        end
    endtask

    // Expected line state after falling edge k of a frame.
    function automatic exp_t expect_at(int k, logic [DW-1:0] s);
        exp_t e;
        e.sd = 1'b0; e.oe = 1'b1; e.sdo = 1'b0; e.sdo2 = 1'b0;
        if (k <= 1) begin
            e.oe = 1'b0; e.tag = "R2";
        end else if (k == 2) begin
            e.tag = "R3";
        end else if (k <= 14) begin
            e.sdo = s[14-k]; e.sdo2 = s[14-k]; e.tag = "R4";
        end else if (k <= 25) begin
            e.sdo = s[k-14]; e.tag = "R5 R10";
        end else begin
            e.tag = "R6 R10";
        end
        return e;
    endfunction

    // Monitor: pop expected states and compare against both instances.
    initial begin
        forever begin
            @(ev_obs);
            while (sbq.size() > 0) begin
                exp_t e;
                e = sbq.pop_front();
                check1(e.tag, "sdo_oe", oe, e.oe);
                check1(e.tag, "sdo", sdo, e.sdo);
                check1(e.tag, "shutdown", sd, e.sd);
                check1(e.tag, "norep sdo_oe", oe2, e.oe);
                check1(e.tag, "norep sdo", sdo2, e.sdo2);
            end
        end
    end

    // One serial clock period; a rising edge first, which must change nothing (R7).
    task automatic fall_edge(exp_t e);
        @(negedge clk) sclk = 1'b1;
        repeat (2) @(negedge clk);
        check1("R7", "sdo_oe after rise", oe, last_e.oe);
        check1("R7", "sdo after rise", sdo, last_e.sdo);
        sclk = 1'b0;
        sbq.push_back(e);
        @(negedge clk);
        ->ev_obs;
        last_e = e;
        @(negedge clk);
    endtask

    task automatic run_frame(logic [DW-1:0] s, int nfalls, bit flip);
        @(negedge clk);
        sample = s;
        cs_n   = 1'b0;
        last_e.oe = 1'b0; last_e.sdo = 1'b0; last_e.sdo2 = 1'b0; last_e.sd = 1'b0;
        for (int k = 1; k <= nfalls; k++) begin
            fall_edge(expect_at(k, s));
            if (k == 2 && flip) sample = ~s;   // R8: change after capture
        end
    endtask

    task automatic end_frame(string tag);
        @(negedge clk) cs_n = 1'b1;
        @(negedge clk);
        check1(tag, "sdo_oe after deselect", oe, 1'b0);
        check1(tag, "shutdown after deselect", sd, 1'b1);
        check1(tag, "sdo after deselect", sdo, 1'b0);
    endtask

    initial begin
        exp_t idle;
        rst_n = 1'b0; cs_n = 1'b1; sclk = 1'b0; sample = '0;
        repeat (4) @(negedge clk);
        check1("R11", "reset sdo_oe", oe, 1'b0);
        check1("R11", "reset sdo", sdo, 1'b0);
        check1("R11", "reset shutdown", sd, 1'b1);
        rst_n = 1'b1;
        sample = 12'hFFF;

        // R1: clocking while deselected leaves the line released.
        idle.oe = 1'b0; idle.sdo = 1'b0; idle.sdo2 = 1'b0; idle.sd = 1'b1; idle.tag = "R1";
        last_e = idle;
        for (int i = 0; i < 3; i++) fall_edge(idle);

        // Full frame with input changed after capture (R8).
        run_frame(12'hA5C, 30, 1'b1);
        end_frame("R1");

        // Aborted frame, then a restarted one (R9).
        run_frame(12'h3F1, 8, 1'b0);
        end_frame("R9");
        run_frame(12'h801, 30, 1'b1);
        end_frame("R9");

        run_frame(12'hFFF, 28, 1'b0);
        end_frame("R1");
        run_frame(12'h000, 16, 1'b0);
        end_frame("R1");

        repeat (4) @(negedge clk);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #(200000 * 4);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule